// File: doc/BRIEF.md
# Register Bitfield Operation Unit

This unit performs one of eight bitfield operations on a 32-bit register operand. A field is named by a bit offset and a width. The offset is counted from the most significant bit, so offset 0 is bit 31. A field that runs past bit 0 continues at bit 31. The caller supplies an operation code, the offset, the width, a destination register value and a second (source) register value. The unit returns three things: the updated destination value, a value for the second register, and negative and zero condition flags.

Internally, every operation brings the selected field up to the most significant bit using a mask aligned there, so a field that wraps needs no special handling. The results are registered. Each set of inputs produces its outputs on the following rising clock edge, and a new operation can be issued every cycle.

Top module: `bfu_unit`

## Requirements
- R1: While `rst` is high on a rising edge, every output is cleared to zero on that edge.
- R2: The outputs produced from a set of inputs appear on the first rising edge after those inputs are applied, and hold until the next edge.
- R3: Only `offset_i` modulo 32 (bits 4:0) selects the field, and the upper offset bits have no effect. Offset k names bit 31−k. A field of width w covers offsets k through k+w−1, taken modulo 32, so it wraps from bit 0 to bit 31.
- R4: A `width_i` of 0 selects a 32-bit field. Values 1 to 31 select that many bits.
- R5: Op code 1 (extract unsigned) writes the field, zero-extended and right-aligned, to `aux_o`.
- R6: Op code 3 (extract signed) writes the field, sign-extended from its first bit and right-aligned, to `aux_o`.
- R7: Op code 6 sets every field bit of the destination. Op code 4 clears every field bit. Op code 2 inverts every field bit. Bits outside the field keep their value.
- R8: Op code 7 (insert) replaces the destination field with the low `width` bits of `src_i`. The lowest source bit goes to the last field position.
- R9: Op code 5 (find first one) returns in `aux_o` the reduced offset plus the index within the field of the first set bit, scanning from the field start. If the field holds no set bit, it returns the reduced offset plus the width.
- R10: For insert, `neg_o` is the first bit of the inserted value and `zero_o` is set when the inserted value is zero. For every other op code, the two flags are taken the same way from the old destination field.
- R11: Op code 0 (test) passes `dst_i` to `dst_o` and `src_i` to `aux_o`. Op codes 1, 3 and 5 pass `dst_i` to `dst_o`. Op codes 2, 4, 6 and 7 pass `src_i` to `aux_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0 test, 1 extract unsigned, 2 change, 3 extract signed, 4 clear, 5 find first one, 6 set, 7 insert) |
| offset_i | input | 32 | Field offset from the MSB; used modulo 32 |
| width_i | input | 5 | Field width; 0 means 32 |
| dst_i | input | 32 | Destination register value |
| src_i | input | 32 | Second register value |
| dst_o | output | 32 | Updated destination value |
| aux_o | output | 32 | Result for the second register |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |

## Verification
All four results (`dst_o`, `aux_o`, `neg_o`, `zero_o`) come from one register stage, so each is due exactly one rising edge after its inputs are applied. The bench drives inputs on the falling edge and compares on the next falling edge, half a cycle after the capturing edge. A directed test changes the inputs and samples before the next rising edge, to confirm the outputs still show the previous operation. The checker compares outputs against inputs delayed by one cycle, and it is armed only once a full operation has passed since reset.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        BF_TST  = 3'd0,
        BF_EXTU = 3'd1,
        BF_CHG  = 3'd2,
        BF_EXTS = 3'd3,
        BF_CLR  = 3'd4,
        BF_FFO  = 3'd5,
        BF_SET  = 3'd6,
        BF_INS  = 3'd7
    } bf_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] aux;
        logic              neg;
        logic              zero;
    } bf_res_t;

endpackage

// File: rtl/bfu_mask.sv
module bfu_mask #(
    parameter int unsigned DATA_W = bfu_pkg::WORD_W,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [SH_W-1:0]   width_i,
    input  logic [SH_W-1:0]   off_i,
    output logic [DATA_W-1:0] mask_msb_o,
    output logic [DATA_W-1:0] mask_inp_o
);
    logic [SH_W:0] full_w;
    logic [SH_W:0] lsh;

    always_comb begin
        full_w     = (width_i == '0) ? (SH_W+1)'(DATA_W) : {1'b0, width_i};
        lsh        = (SH_W+1)'(DATA_W) - full_w;
        mask_msb_o = {DATA_W{1'b1}} << lsh;
        mask_inp_o = (mask_msb_o >> off_i) | (mask_msb_o << (DATA_W - 32'(off_i)));
    end
endmodule

// File: rtl/bfu_lzc.sv
module bfu_lzc #(
    parameter int unsigned DATA_W = bfu_pkg::WORD_W,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] vec_i,
    output logic [SH_W:0]     cnt_o
);
    logic found;

    always_comb begin
        cnt_o = (SH_W+1)'(DATA_W);
        found = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (!found && vec_i[i]) begin
                cnt_o = (SH_W+1)'(DATA_W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bfu_core.sv
module bfu_core
    import bfu_pkg::*;
#(
    parameter int unsigned DATA_W = bfu_pkg::WORD_W,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  bf_op_e            op_i,
    input  logic [DATA_W-1:0] offset_i,
    input  logic [SH_W-1:0]   width_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    output bf_res_t           res_o
);
    function automatic logic [DATA_W-1:0] rot_r(logic [DATA_W-1:0] x, logic [SH_W-1:0] s);
        return (x >> s) | (x << (DATA_W - 32'(s)));
    endfunction

    function automatic logic [DATA_W-1:0] rot_l(logic [DATA_W-1:0] x, logic [SH_W-1:0] s);
        return (x << s) | (x >> (DATA_W - 32'(s)));
    endfunction

    logic [SH_W-1:0]   off;
    logic [SH_W:0]     full_w;
    logic [SH_W:0]     rsh;
    logic [DATA_W-1:0] mask_msb;
    logic [DATA_W-1:0] mask_inp;
    logic [DATA_W-1:0] old_inp;
    logic [DATA_W-1:0] old_msb;
    logic [DATA_W-1:0] ins_msb;
    logic [DATA_W-1:0] ins_inp;
    logic [DATA_W-1:0] flag_src;
    logic [DATA_W-1:0] ffo_vec;
    logic [SH_W:0]     lead_cnt;

    assign off = offset_i[SH_W-1:0];

    bfu_mask #(.DATA_W(DATA_W)) u_mask (
        .width_i    (width_i),
        .off_i      (off),
        .mask_msb_o (mask_msb),
        .mask_inp_o (mask_inp)
    );

    always_comb begin
        full_w   = (width_i == '0) ? (SH_W+1)'(DATA_W) : {1'b0, width_i};
        rsh      = (SH_W+1)'(DATA_W) - full_w;
        old_inp  = dst_i & mask_inp;
        old_msb  = rot_l(old_inp, off);
        ins_msb  = rot_r(src_i, width_i) & mask_msb;
        ins_inp  = rot_r(ins_msb, off);
        ffo_vec  = old_msb | ~mask_msb;
    end

    bfu_lzc #(.DATA_W(DATA_W)) u_lzc (
        .vec_i (ffo_vec),
        .cnt_o (lead_cnt)
    );

    always_comb begin
        res_o.dst = dst_i;
        res_o.aux = src_i;
        unique case (op_i)
            BF_TST:  ;
            BF_EXTU: res_o.aux = old_msb >> rsh;
            BF_EXTS: res_o.aux = $unsigned($signed(old_msb) >>> rsh);
            BF_CHG:  res_o.dst = dst_i ^ mask_inp;
            BF_CLR:  res_o.dst = dst_i & ~mask_inp;
            BF_SET:  res_o.dst = dst_i | mask_inp;
            BF_FFO:  res_o.aux = DATA_W'(off) + DATA_W'(lead_cnt);
            BF_INS:  res_o.dst = (dst_i & ~mask_inp) | ins_inp;
            default: ;
        endcase
        flag_src   = (op_i == BF_INS) ? ins_msb : old_msb;
        res_o.neg  = flag_src[DATA_W-1];
        res_o.zero = (flag_src == '0);
    end
endmodule

// File: rtl/bfu_unit.sv
module bfu_unit
    import bfu_pkg::*;
#(
    parameter int unsigned DATA_W = bfu_pkg::WORD_W,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] offset_i,
    input  logic [SH_W-1:0]   width_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [DATA_W-1:0] dst_o,
    output logic [DATA_W-1:0] aux_o,
    output logic              neg_o,
    output logic              zero_o
);
    bf_res_t res_d;
    bf_res_t res_q;

    bfu_core #(.DATA_W(DATA_W)) u_core (
        .op_i     (bf_op_e'(op_i)),
        .offset_i (offset_i),
        .width_i  (width_i),
        .dst_i    (dst_i),
        .src_i    (src_i),
        .res_o    (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign dst_o  = res_q.dst;
    assign aux_o  = res_q.aux;
    assign neg_o  = res_q.neg;
    assign zero_o = res_q.zero;
endmodule

// File: rtl/bfu_unit_chk.sv
module bfu_unit_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        op_i,
    input logic [DATA_W-1:0] dst_i,
    input logic [DATA_W-1:0] src_i,
    input logic [DATA_W-1:0] dst_o,
    input logic [DATA_W-1:0] aux_o,
    input logic              neg_o,
    input logic              zero_o
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (dst_o == '0 && aux_o == '0 && !neg_o && !zero_o));

    // R11
    test_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_i) == 3'd0) |-> (dst_o == $past(dst_i) && aux_o == $past(src_i)));

    // R11
    extract_keeps_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && ($past(op_i) == 3'd1 || $past(op_i) == 3'd3 || $past(op_i) == 3'd5))
        |-> dst_o == $past(dst_i));

    // R7
    set_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_i) == 3'd6) |-> ((dst_o & $past(dst_i)) == $past(dst_i)));

    // R7
    clear_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_i) == 3'd4) |-> ((dst_o & ~$past(dst_i)) == '0));

    // R10
    extu_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_i) == 3'd1) |-> (zero_o == (aux_o == '0)));

    // R6
    exts_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_i) == 3'd3) |-> (neg_o == aux_o[DATA_W-1]));
endmodule

bind bfu_unit bfu_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op_i),
    .dst_i  (dst_i),
    .src_i  (src_i),
    .dst_o  (dst_o),
    .aux_o  (aux_o),
    .neg_o  (neg_o),
    .zero_o (zero_o)
);

// File: tb/bfu_unit_bench.sv
module bfu_unit_bench;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] off;
        logic [4:0]  wid;
        logic [31:0] dst;
        logic [31:0] src;
        logic [31:0] e_dst;
        logic [31:0] e_aux;
        logic        e_n;
        logic        e_z;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 32'd4,  5'd8, 32'h12345678, 32'hDEADBEEF, 32'h12345678, 32'h00000023, 1'b0, 1'b0}, // R5
        '{3'd3, 32'd0,  5'd4, 32'hF0000000, 32'h11111111, 32'hF0000000, 32'hFFFFFFFF, 1'b1, 1'b0}, // R6
        '{3'd3, 32'd8,  5'd8, 32'h12345678, 32'h0,        32'h12345678, 32'h00000034, 1'b0, 1'b0}, // R6
        '{3'd4, 32'd28, 5'd8, 32'hFFFFFFFF, 32'h00000077, 32'h0FFFFFF0, 32'h00000077, 1'b1, 1'b0}, // R7 R3 wrap
        '{3'd6, 32'd30, 5'd4, 32'h00000000, 32'h00000001, 32'hC0000003, 32'h00000001, 1'b0, 1'b1}, // R7 R3 wrap
        '{3'd2, 32'd16, 5'd16,32'h0000FFFF, 32'h00000002, 32'h00000000, 32'h00000002, 1'b1, 1'b0}, // R7
        '{3'd7, 32'd8,  5'd8, 32'h12345678, 32'h000000AB, 32'h12AB5678, 32'h000000AB, 1'b1, 1'b0}, // R8 R10
        '{3'd7, 32'd28, 5'd8, 32'h00000000, 32'h0000005A, 32'hA0000005, 32'h0000005A, 1'b0, 1'b0}, // R8 wrap
        '{3'd5, 32'd4,  5'd8, 32'h00100000, 32'h0,        32'h00100000, 32'd11,       1'b0, 1'b0}, // R9
        '{3'd5, 32'd10, 5'd6, 32'h00000000, 32'h0,        32'h00000000, 32'd16,       1'b0, 1'b1}, // R9 empty
        '{3'd0, 32'd0,  5'd0, 32'h80000001, 32'h00000055, 32'h80000001, 32'h00000055, 1'b1, 1'b0}, // R11 R4
        '{3'd1, 32'd4,  5'd0, 32'h12345678, 32'h0,        32'h12345678, 32'h23456781, 1'b0, 1'b0}, // R4
        '{3'd1, 32'd36, 5'd8, 32'h12345678, 32'h0,        32'h12345678, 32'h00000023, 1'b0, 1'b0}, // R3 upper bits
        '{3'd5, 32'd30, 5'd4, 32'h80000000, 32'h0,        32'h80000000, 32'd32,       1'b0, 1'b0}, // R9 wrap
        '{3'd7, 32'd16, 5'd0, 32'h00000000, 32'h12345678, 32'h56781234, 32'h12345678, 1'b0, 1'b0}, // R8 R4
        '{3'd4, 32'd0,  5'd4, 32'h0FFFFFFF, 32'h00000009, 32'h0FFFFFFF, 32'h00000009, 1'b0, 1'b1}  // R10 zero
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = '0;
    logic [31:0] offset_i = '0;
    logic [4:0]  width_i = '0;
    logic [31:0] dst_i = '0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_o;
    logic [31:0] aux_o;
    logic        neg_o;
    logic        zero_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bfu_unit u_bfu_unit (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op_i),
        .offset_i (offset_i),
        .width_i  (width_i),
        .dst_i    (dst_i),
        .src_i    (src_i),
        .dst_o    (dst_o),
        .aux_o    (aux_o),
        .neg_o    (neg_o),
        .zero_o   (zero_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_i     = v.op;
        offset_i = v.off;
        width_i  = v.wid;
        dst_i    = v.dst;
        src_i    = v.src;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        drive(VEC[0]);
        @(negedge clk);
        // R1: inputs applied while reset is held must not reach the outputs
        check("R1 dst", dst_o, 32'h0);
        check("R1 aux", aux_o, 32'h0);
        check("R1 flags", {30'h0, neg_o, zero_o}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check($sformatf("R2 vec%0d dst", i), dst_o, VEC[i].e_dst);
            check($sformatf("R2 vec%0d aux", i), aux_o, VEC[i].e_aux);
            check($sformatf("R10 vec%0d flags", i), {30'h0, neg_o, zero_o},
                  {30'h0, VEC[i].e_n, VEC[i].e_z});
        end

        // R2: new inputs do not show before the next rising edge
        drive(VEC[6]);
        #1;
        check("R2 hold aux", aux_o, VEC[NV-1].e_aux);
        check("R2 hold dst", dst_o, VEC[NV-1].e_dst);
        @(negedge clk);
        check("R2 update dst", dst_o, VEC[6].e_dst);

        // R3: full-width wrap of a change field, offset 31 width 2 -> bits 0 and 31
        op_i = 3'd2; offset_i = 32'hFFFF_FFFF; width_i = 5'd2; dst_i = 32'h0; src_i = 32'h3;
        @(negedge clk);
        check("R3 wrap chg", dst_o, 32'h80000001);
        check("R11 chg aux", aux_o, 32'h3);

        // R1: reset in the middle clears outputs again
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset", dst_o | aux_o, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule